// File: doc/BRIEF.md
# ARINC 429 Serial Word Receiver

This block turns one ARINC 429 line into parallel 32-bit words. An external comparator gives three synchronous level flags (one, zero, null). The block samples them into short shift histories. It accepts a data bit only when a clean pulse of one or zero is followed by a return to null. It also checks that consecutive bits are spaced correctly. After the 32nd bit it presents the word for one cycle with a strobe.

Bit 32 of the presented word is replaced by a parity-error flag. Reception is armed only after a quiet line has been seen for a full word gap, and any timing violation discards the partial word. A self-test input replaces the comparator flags with the digital output of a local transmitter. A rate input selects high-speed sampling (one sample per master clock) or low-speed sampling (one sample every 8 master clocks). With this choice the same sample-count rules hold at both rates.

Top module: `a429_rx`

## Requirements
- R1: While rst_ni is low and after its release, eos_o is 0 and word_o is all zeros. The block then waits for a word gap before it accepts any bit.
- R2: With rate_lo_i = 0 the level inputs are sampled on every clock. With rate_lo_i = 1 they are sampled once every 8 clocks. Pulses timed for the fast rate therefore never produce a word at the slow rate.
- R3: A bit is recognised only when three consecutive samples of one (value 1) or of zero (value 0) are followed by three consecutive null samples. A pulse of two samples is never recognised.
- R4: Within a word, each recognised bit must come 8 to 12 samples after the previous one, both limits included. A spacing of 7 or of 13 discards the word.
- R5: If 12 samples pass within a word without a recognised bit, the partial word is discarded.
- R6: A gap check runs every 10 samples. It passes when the 5 newest samples contain three consecutive nulls and the 5 oldest samples of the 10-sample null history do too. Reception is armed only after three consecutive checks pass. A word sent without such a gap is ignored, and so is a word sent after a gap of only 15 samples.
- R7: After the 32nd accepted bit, eos_o is high for exactly one cycle. In that cycle word_o holds the word, with the first received bit in word_o[0].
- R8: word_o[31] is 0 when the 32 received bits hold an odd number of ones, and 1 when they hold an even number.
- R9: With self_test_i = 1, the levels come from tx_one_i and tx_zero_i, with null meaning both are low. The comparator inputs are then ignored.
- R10: After any discarded word, a correctly timed word that follows a valid gap is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rate_lo_i | input | 1 | 0: sample every clock, 1: sample every 8 clocks |
| self_test_i | input | 1 | Select transmitter loopback levels |
| lvl_one_i | input | 1 | Comparator: line at one level |
| lvl_zero_i | input | 1 | Comparator: line at zero level |
| lvl_null_i | input | 1 | Comparator: line at null level |
| tx_one_i | input | 1 | Loopback: transmitter drives one |
| tx_zero_i | input | 1 | Loopback: transmitter drives zero |
| eos_o | output | 1 | One-cycle end-of-sequence strobe |
| word_o | output | 32 | Received word, bit 31 is the parity-error flag |

## Verification
The assertions assume that at most one comparator flag is high at a time. They also assume that the rate and self-test selects change only while the line sits at null between words. The bench keeps to this by deriving the null flag from the other two and by holding each level for a whole number of samples. It switches rate or loopback only inside long null stretches. Under these conditions, the one-cycle strobe and the arming order (a gap that passes its checks before the first bit) can be checked as plain clocked properties.

// File: rtl/a429_rx_pkg.sv
package a429_rx_pkg;
  localparam int WORD_BITS = 32;
  localparam int SR_LEN    = 10;
  localparam int QUAL      = 3;
  localparam int LO_DIV    = 8;
  localparam int SPC_MIN   = 8;
  localparam int SPC_MAX   = 12;
  localparam int GAP_TICK  = 10;
  localparam int GAP_NEED  = 3;

  typedef enum logic [0:0] {
    ST_GAP  = 1'b0,
    ST_WORD = 1'b1
  } rx_state_e;
endpackage

// File: rtl/a429_rx_sampler.sv
module a429_rx_sampler
  import a429_rx_pkg::*;
#(
  parameter int SR_W   = SR_LEN,
  parameter int Q_W    = QUAL,
  parameter int DIV_LO = LO_DIV
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rate_lo_i,
  input  logic              one_i,
  input  logic              zero_i,
  input  logic              null_i,
  output logic              upd_o,
  output logic [2*Q_W-1:0]  one_sr_o,
  output logic [2*Q_W-1:0]  zero_sr_o,
  output logic [SR_W-1:0]   null_sr_o
);
  localparam int DW = (DIV_LO > 1) ? $clog2(DIV_LO) : 1;
  localparam int LW = 2 * Q_W;

  logic [DW-1:0] div_q;
  logic          div_end, smp;

  assign div_end = (div_q == DW'(DIV_LO - 1));
  assign smp     = rate_lo_i ? div_end : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q     <= '0;
      upd_o     <= 1'b0;
      one_sr_o  <= '0;
      zero_sr_o <= '0;
      null_sr_o <= '0;
    end else begin
      div_q <= div_end ? '0 : div_q + 1'b1;
      upd_o <= smp;
      if (smp) begin
        one_sr_o  <= {one_sr_o[LW-2:0], one_i};
        zero_sr_o <= {zero_sr_o[LW-2:0], zero_i};
        null_sr_o <= {null_sr_o[SR_W-2:0], null_i};
      end
    end
  end

  a_r2_lo_rate_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_o && rate_lo_i) |=> !upd_o);
  a_r2_hi_rate_every: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rate_lo_i |=> upd_o);
endmodule

// File: rtl/a429_rx_bitdet.sv
module a429_rx_bitdet
  import a429_rx_pkg::*;
#(
  parameter int Q_W = QUAL
) (
  input  logic             upd_i,
  input  logic [2*Q_W-1:0] one_sr_i,
  input  logic [2*Q_W-1:0] zero_sr_i,
  input  logic [Q_W-1:0]   null_lo_i,
  output logic             det_o,
  output logic             bit_o
);
  logic tail_null, hit_one, hit_zero;

  // pulse of Q_W samples, then Q_W clean null samples
  assign tail_null = &null_lo_i;
  assign hit_one   = (&one_sr_i[2*Q_W-1:Q_W]) && !(|one_sr_i[Q_W-1:0]) && tail_null;
  assign hit_zero  = (&zero_sr_i[2*Q_W-1:Q_W]) && !(|zero_sr_i[Q_W-1:0]) && tail_null;

  assign det_o = upd_i && (hit_one || hit_zero);
  assign bit_o = hit_one;
endmodule

// File: rtl/a429_rx_gap.sv
module a429_rx_gap
  import a429_rx_pkg::*;
#(
  parameter int SR_W  = SR_LEN,
  parameter int Q_W   = QUAL,
  parameter int TICK  = GAP_TICK,
  parameter int NEED  = GAP_NEED
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            upd_i,
  input  logic            wait_i,
  input  logic [SR_W-1:0] null_sr_i,
  output logic            arm_o
);
  localparam int HALF = SR_W / 2;
  localparam int TW   = (TICK > 1) ? $clog2(TICK) : 1;
  localparam int GW   = (NEED > 1) ? $clog2(NEED) : 1;

  logic [TW-1:0] tcnt_q;
  logic [GW-1:0] gcnt_q;
  logic          lo_run, hi_run, tick_hit, quiet;

  always_comb begin
    lo_run = 1'b0;
    hi_run = 1'b0;
    for (int i = 0; i <= HALF - Q_W; i++) begin
      lo_run = lo_run | (&null_sr_i[i +: Q_W]);
      hi_run = hi_run | (&null_sr_i[HALF + i +: Q_W]);
    end
  end

  assign quiet    = lo_run && hi_run;
  assign tick_hit = (tcnt_q == TW'(TICK - 1));
  assign arm_o    = wait_i && upd_i && tick_hit && quiet && (gcnt_q == GW'(NEED - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tcnt_q <= '0;
      gcnt_q <= '0;
    end else if (!wait_i) begin
      tcnt_q <= '0;
      gcnt_q <= '0;
    end else if (upd_i) begin
      if (tick_hit) begin
        tcnt_q <= '0;
        if (!quiet || gcnt_q == GW'(NEED - 1)) gcnt_q <= '0;
        else                                   gcnt_q <= gcnt_q + 1'b1;
      end else begin
        tcnt_q <= tcnt_q + 1'b1;
      end
    end
  end

  a_r6_arm_leaves_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_o |=> !wait_i);
  a_r6_gcnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gcnt_q <= GW'(NEED - 1));
endmodule

// File: rtl/a429_rx.sv
module a429_rx
  import a429_rx_pkg::*;
#(
  parameter int W_BITS = WORD_BITS,
  parameter int SR_W   = SR_LEN,
  parameter int Q_W    = QUAL,
  parameter int DIV_LO = LO_DIV,
  parameter int S_MIN  = SPC_MIN,
  parameter int S_MAX  = SPC_MAX,
  parameter int TICK   = GAP_TICK,
  parameter int NEED   = GAP_NEED
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rate_lo_i,
  input  logic              self_test_i,
  input  logic              lvl_one_i,
  input  logic              lvl_zero_i,
  input  logic              lvl_null_i,
  input  logic              tx_one_i,
  input  logic              tx_zero_i,
  output logic              eos_o,
  output logic [W_BITS-1:0] word_o
);
  localparam int CW = $clog2(W_BITS);
  localparam int SW = $clog2(S_MAX + 1);

  logic             one_s, zero_s, null_s;
  logic             upd, det, det_bit, arm;
  logic [2*Q_W-1:0] one_sr, zero_sr;
  logic [SR_W-1:0]  null_sr;

  rx_state_e          state_q;
  logic [CW-1:0]      bit_cnt_q;
  logic [SW-1:0]      spc_q;
  logic [W_BITS-1:0]  data_q;
  logic               done_q;
  logic               spc_bad, spc_late, last_bit;

  assign one_s  = self_test_i ? tx_one_i  : lvl_one_i;
  assign zero_s = self_test_i ? tx_zero_i : lvl_zero_i;
  assign null_s = self_test_i ? !(tx_one_i || tx_zero_i) : lvl_null_i;

  a429_rx_sampler #(.SR_W(SR_W), .Q_W(Q_W), .DIV_LO(DIV_LO)) i_sampler (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rate_lo_i (rate_lo_i),
    .one_i     (one_s),
    .zero_i    (zero_s),
    .null_i    (null_s),
    .upd_o     (upd),
    .one_sr_o  (one_sr),
    .zero_sr_o (zero_sr),
    .null_sr_o (null_sr)
  );

  a429_rx_bitdet #(.Q_W(Q_W)) i_bitdet (
    .upd_i     (upd),
    .one_sr_i  (one_sr),
    .zero_sr_i (zero_sr),
    .null_lo_i (null_sr[Q_W-1:0]),
    .det_o     (det),
    .bit_o     (det_bit)
  );

  a429_rx_gap #(.SR_W(SR_W), .Q_W(Q_W), .TICK(TICK), .NEED(NEED)) i_gap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .upd_i     (upd),
    .wait_i    (state_q == ST_GAP),
    .null_sr_i (null_sr),
    .arm_o     (arm)
  );

  // spc_q counts samples since the last accepted bit, so spacing = spc_q + 1
  assign spc_bad  = (bit_cnt_q != '0) &&
                    (spc_q < SW'(S_MIN - 1) || spc_q > SW'(S_MAX - 1));
  assign spc_late = (bit_cnt_q != '0) && (spc_q >= SW'(S_MAX - 1));
  assign last_bit = (bit_cnt_q == CW'(W_BITS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_GAP;
      bit_cnt_q <= '0;
      spc_q     <= '0;
      data_q    <= '0;
      done_q    <= 1'b0;
      eos_o     <= 1'b0;
      word_o    <= '0;
    end else begin
      done_q <= 1'b0;
      eos_o  <= done_q;
      if (done_q) word_o <= {~^data_q, data_q[W_BITS-2:0]};
      unique case (state_q)
        ST_GAP: begin
          if (arm) begin
            state_q   <= ST_WORD;
            bit_cnt_q <= '0;
            spc_q     <= '0;
          end
        end
        ST_WORD: begin
          if (upd) begin
            if (det) begin
              if (spc_bad) begin
                state_q   <= ST_GAP;
                bit_cnt_q <= '0;
              end else begin
                data_q[bit_cnt_q] <= det_bit;
                spc_q             <= '0;
                if (last_bit) begin
                  state_q   <= ST_GAP;
                  bit_cnt_q <= '0;
                  done_q    <= 1'b1;
                end else begin
                  bit_cnt_q <= bit_cnt_q + 1'b1;
                end
              end
            end else if (spc_late) begin
              state_q   <= ST_GAP;
              bit_cnt_q <= '0;
            end else if (spc_q != SW'(S_MAX)) begin
              spc_q <= spc_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_GAP;
      endcase
    end
  end

  a_r7_eos_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eos_o |=> !eos_o);
  a_r7_eos_after_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eos_o |-> $past(state_q == ST_WORD, 2));
  a_r6_arm_on_quiet_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == ST_GAP && state_q == ST_WORD) |-> $past(null_sr[0] || null_sr[SR_W-1]));
  a_r4_count_on_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_cnt_q != $past(bit_cnt_q)) |-> $past(upd));
endmodule

// File: tb/test_a429_rx.sv
module test_a429_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rate_lo = 1'b0, self_test = 1'b0;
  logic        lv_one = 1'b0, lv_zero = 1'b0, lv_null = 1'b1;
  logic        tx_one = 1'b0, tx_zero = 1'b0;
  logic        eos;
  logic [31:0] word;

  int          errs = 0, checks = 0;
  int          eos_cnt = 0, eos_run = 0, eos_long = 0;
  logic [31:0] last_w = '0;
  int          div = 1;
  bit          use_tx = 1'b0;

  always #10 clk = ~clk;

  a429_rx i_a429_rx (
    .clk_i(clk), .rst_ni(rst_n), .rate_lo_i(rate_lo), .self_test_i(self_test),
    .lvl_one_i(lv_one), .lvl_zero_i(lv_zero), .lvl_null_i(lv_null),
    .tx_one_i(tx_one), .tx_zero_i(tx_zero), .eos_o(eos), .word_o(word)
  );

  always @(negedge clk) begin
    if (rst_n && eos) begin
      eos_cnt++;
      last_w = word;
      eos_run++;
      if (eos_run > 1) eos_long++;
    end else begin
      eos_run = 0;
    end
  end

  localparam int NV = 8;
  localparam logic [31:0] V_W [NV] = '{32'h0000_0001, 32'hA5A5_F00F, 32'h8000_0000,
    32'h7FFF_FFFF, 32'h1234_5678, 32'hFFFF_FFFF, 32'h0F0F_0F0F, 32'h0000_0000};
  localparam int V_HI [NV] = '{5, 5, 4, 6, 7, 4, 2, 5};
  localparam int V_LO [NV] = '{5, 5, 4, 6, 6, 3, 8, 5};
  localparam bit V_OK [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};
  localparam string V_REQ [NV] = '{"R7", "R8", "R4", "R4", "R4", "R4", "R3", "R10"};

  function automatic logic [31:0] expw(input logic [31:0] w);
    return {~^w, w[30:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic o, input logic z, input int n);
    if (use_tx) begin
      tx_one = o; tx_zero = z;
    end else begin
      lv_one = o; lv_zero = z; lv_null = !o && !z;
    end
    repeat (n * div) @(negedge clk);
  endtask

  task automatic send_bits(input logic [31:0] w, input int first, input int last,
                           input int hi, input int lo);
    for (int i = first; i <= last; i++) begin
      put(w[i], !w[i], hi);
      put(1'b0, 1'b0, lo);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int c0;
    repeat (5) @(negedge clk);
    chk("R1 eos in reset", 32'(eos), 32'd0);
    chk("R1 word in reset", word, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 word after reset", word, 32'd0);

    // R6: word without a preceding gap is ignored
    c0 = eos_cnt;
    put(1'b0, 1'b0, 5);
    send_bits(32'hDEAD_BEEF, 0, 31, 5, 5);
    put(1'b0, 1'b0, 50);
    chk("R6 no gap", 32'(eos_cnt - c0), 32'd0);

    for (int k = 0; k < NV; k++) begin
      c0 = eos_cnt;
      put(1'b0, 1'b0, 50);
      send_bits(V_W[k], 0, 31, V_HI[k], V_LO[k]);
      put(1'b0, 1'b0, 50);
      chk(V_REQ[k], 32'(eos_cnt - c0), 32'(V_OK[k]));
      if (V_OK[k]) chk(V_REQ[k], last_w, expw(V_W[k]));
    end

    // R6: second word after a short gap is ignored
    c0 = eos_cnt;
    put(1'b0, 1'b0, 50);
    send_bits(32'h0000_00C3, 0, 31, 5, 5);
    put(1'b0, 1'b0, 15);
    send_bits(32'h5555_0000, 0, 31, 5, 5);
    put(1'b0, 1'b0, 50);
    chk("R6 short gap count", 32'(eos_cnt - c0), 32'd1);
    chk("R6 short gap word", last_w, expw(32'h0000_00C3));

    // R5: pause inside a word
    c0 = eos_cnt;
    put(1'b0, 1'b0, 50);
    send_bits(32'h3C3C_3C3C, 0, 15, 5, 5);
    put(1'b0, 1'b0, 20);
    send_bits(32'h3C3C_3C3C, 16, 31, 5, 5);
    put(1'b0, 1'b0, 50);
    chk("R5 timeout", 32'(eos_cnt - c0), 32'd0);

    // R10: recovery
    c0 = eos_cnt;
    put(1'b0, 1'b0, 50);
    send_bits(32'h0BAD_F00D, 0, 31, 5, 5);
    put(1'b0, 1'b0, 50);
    chk("R10 recovery count", 32'(eos_cnt - c0), 32'd1);
    chk("R10 recovery word", last_w, expw(32'h0BAD_F00D));

    // R9: loopback with comparator held at one
    use_tx = 1'b1;
    tx_one = 1'b0; tx_zero = 1'b0;
    self_test = 1'b1;
    lv_one = 1'b1; lv_zero = 1'b0; lv_null = 1'b0;
    c0 = eos_cnt;
    put(1'b0, 1'b0, 50);
    send_bits(32'hC001_D00D, 0, 31, 5, 5);
    put(1'b0, 1'b0, 50);
    chk("R9 loopback count", 32'(eos_cnt - c0), 32'd1);
    chk("R9 loopback word", last_w, expw(32'hC001_D00D));
    lv_one = 1'b0; lv_null = 1'b1;
    self_test = 1'b0;
    use_tx = 1'b0;
    put(1'b0, 1'b0, 50);

    // R2: low-rate sampling
    rate_lo = 1'b1;
    div = 8;
    c0 = eos_cnt;
    put(1'b0, 1'b0, 50);
    send_bits(32'h1357_9BDF, 0, 31, 5, 5);
    put(1'b0, 1'b0, 50);
    chk("R2 low rate count", 32'(eos_cnt - c0), 32'd1);
    chk("R2 low rate word", last_w, expw(32'h1357_9BDF));

    c0 = eos_cnt;
    div = 1;
    send_bits(32'h2468_ACE0, 0, 31, 5, 5);
    div = 8;
    put(1'b0, 1'b0, 50);
    chk("R2 fast pulses at low rate", 32'(eos_cnt - c0), 32'd0);

    chk("R7 strobe width", 32'(eos_long), 32'd0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule